// File: doc/BRIEF.md
# Single-Level Paged Address Translator

This block turns a 16-bit virtual address into a 15-bit physical address through a small page table kept in internal registers. The top four address bits select one of sixteen table entries. Each entry carries a residency flag and a 3-bit frame number. The twelve low bits are the offset within a 4 KB page, and they pass into the physical address unchanged.

A request with a valid strobe yields a registered result one cycle later. If the selected entry is resident, the block raises the address-valid output and drives the frame number concatenated with the offset. If the entry is not resident, it raises a fault output and leaves the address-valid output low. A controller fills or changes entries through a separate write port, one entry per cycle. A write to the entry being looked up in the same cycle is forwarded, so the lookup sees the new contents. Reset clears every residency flag, so every lookup faults until software loads the table.

Top module: `page_xlate`

## Requirements
- R1: After reset every entry is non-resident, so any lookup issued before a table write returns fault=1 and pa_valid=0.
- R2: A lookup presented with req_valid=1 at clock edge N produces its result at edge N+1. When req_valid=0 at edge N, both pa_valid and fault are 0 after edge N+1.
- R3: For a resident entry, pa[14:12] equals the frame number stored at index va[15:12], and pa[11:0] equals va[11:0].
- R4: A lookup of a non-resident entry gives fault=1 and pa_valid=0. pa_valid and fault are never 1 together.
- R5: When wr_en=1 at an edge, entry wr_idx takes wr_present and wr_frame. All other entries keep their contents.
- R6: When wr_en=1 and wr_idx equals va[15:12] at the same edge as a lookup, the result reflects the written present bit and frame.
- R7: Writing wr_present=0 to a resident entry makes later lookups of that entry fault.
- R8: While pa_valid=0, pa holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| va | input | 16 | Virtual address |
| wr_en | input | 1 | Table write enable |
| wr_idx | input | 4 | Entry to write |
| wr_present | input | 1 | Residency flag to store |
| wr_frame | input | 3 | Frame number to store |
| pa_valid | output | 1 | Translation result valid |
| pa | output | 15 | Physical address |
| fault | output | 1 | Page fault for the previous request |

## Verification
The bench drives a lookup to the same entry that is being written in that cycle, in both directions. A design without forwarding would return the old frame, or would report a fault on a page that was just mapped. Entries 0 and 15 and the extreme offsets 0x000 and 0xFFF are exercised, so a design that sliced the page index or offset incorrectly would return a corrupted address. Unmapping a resident page catches a design that updates only the frame and leaves a stale residency flag. Idle cycles between requests catch a design whose valid or fault outputs stay asserted.

// File: rtl/page_xlate.sv
module page_xlate #(
  parameter int VA_W  = 16,
  parameter int OFF_W = 12,
  parameter int FRM_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [VA_W-1:0]          va,
  input  logic                     wr_en,
  input  logic [VA_W-OFF_W-1:0]    wr_idx,
  input  logic                     wr_present,
  input  logic [FRM_W-1:0]         wr_frame,
  output logic                     pa_valid,
  output logic [FRM_W+OFF_W-1:0]   pa,
  output logic                     fault
);
  localparam int IDX_W   = VA_W - OFF_W;
  localparam int ENTRIES = 1 << IDX_W;
  localparam int PA_W    = FRM_W + OFF_W;

  logic [ENTRIES-1:0] present;
  logic [FRM_W-1:0]   frame [ENTRIES];

  wire [IDX_W-1:0] vpn = va[VA_W-1:OFF_W];
  wire             hit_wr  = wr_en && (wr_idx == vpn);
  wire             lk_pres = hit_wr ? wr_present : present[vpn];
  wire [FRM_W-1:0] lk_frm  = hit_wr ? wr_frame   : frame[vpn];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      present <= '0;
    end else if (wr_en) begin
      present[wr_idx] <= wr_present;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) frame[wr_idx] <= wr_frame;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_valid <= 1'b0;
      fault    <= 1'b0;
      pa       <= '0;
    end else begin
      pa_valid <= req_valid && lk_pres;
      fault    <= req_valid && !lk_pres;
      pa       <= (req_valid && lk_pres) ? {lk_frm, va[OFF_W-1:0]} : '0;
    end
  end

  // R4
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(pa_valid && fault));
  // R2
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !pa_valid && !fault);
  // R2
  resp_chk: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> pa_valid || fault);
  // R3
  off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !pa_valid || (pa[OFF_W-1:0] == $past(va[OFF_W-1:0])));
  // R8
  zero_chk: assert property (@(posedge clk) disable iff (!rst_n) !pa_valid |-> pa == '0);
  // R6
  fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && wr_en && wr_idx == va[VA_W-1:OFF_W] |=> pa_valid == $past(wr_present));
endmodule

// File: tb/sim_page_xlate.sv
module sim_page_xlate;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [15:0] va = 0;
  logic wr_en = 0;
  logic [3:0] wr_idx = 0;
  logic wr_present = 0;
  logic [2:0] wr_frame = 0;
  logic pa_valid, fault;
  logic [14:0] pa;

  int checks = 0, fails = 0;
  bit m_pres [16];
  int m_frm [16];
  bit exp_v, exp_f;
  int exp_pa;
  string cur_req;

  page_xlate u0 (.clk, .rst_n, .req_valid, .va, .wr_en, .wr_idx, .wr_present, .wr_frame,
                 .pa_valid, .pa, .fault);

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD*200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic check_out(string tag);
    checks++;
    if (pa_valid !== exp_v || fault !== exp_f || pa !== exp_pa[14:0]) begin
      fails++;
      $display("FAIL %s: got v=%0b f=%0b pa=%h, expected v=%0b f=%0b pa=%h",
               tag, pa_valid, fault, pa, exp_v, exp_f, exp_pa[14:0]);
    end
  endtask

  // one cycle: drive inputs, model the edge, then check the registered outputs
  task automatic cyc(bit rv, logic [15:0] a, bit we, int idx, bit pr, int fr, string tag);
    int p;
    bit pres;
    int frm;
    req_valid = rv; va = a; wr_en = we; wr_idx = idx[3:0]; wr_present = pr; wr_frame = fr[2:0];
    p = a[15:12];
    pres = (we && idx == p) ? pr : m_pres[p];
    frm  = (we && idx == p) ? fr : m_frm[p];
    if (we) begin m_pres[idx] = pr; m_frm[idx] = fr; end
    exp_v = rv && pres;
    exp_f = rv && !pres;
    exp_pa = exp_v ? (frm << 12) | a[11:0] : 0;
    @(posedge clk);
    #1;
    check_out(tag);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin m_pres[i] = 0; m_frm[i] = 0; end
    #(CLK_PERIOD*2 + 2);
    rst_n = 1;
    exp_v = 0; exp_f = 0; exp_pa = 0;
    check_out("R1 reset outputs");
    cyc(1, 16'h0000, 0, 0, 0, 0, "R1 lookup page0 after reset");
    cyc(1, 16'hF123, 0, 0, 0, 0, "R1 lookup page15 after reset");
    cyc(0, 16'h0000, 0, 0, 0, 0, "R2 idle");
    // load table
    for (int i = 0; i < 16; i++)
      cyc(0, 16'h0000, 1, i, (i % 3) != 2, (i * 5) % 8, "R5 table load idle");
    cyc(1, 16'h0000, 0, 0, 0, 0, "R3 page0 offset 000");
    cyc(1, 16'hFFFF, 0, 0, 0, 0, "R3 page15 offset FFF");
    cyc(1, 16'h2ABC, 0, 0, 0, 0, "R4 nonresident page2");
    cyc(1, 16'h5123, 0, 0, 0, 0, "R4 nonresident page5");
    cyc(1, 16'h7FFF, 0, 0, 0, 0, "R3 page7");
    cyc(0, 16'h7FFF, 0, 0, 0, 0, "R2 R8 idle after hit");
    for (int i = 0; i < 16; i++)
      cyc(1, 16'(i << 12) | 16'(i * 257 % 4096), 0, 0, 0, 0, "R3 R4 R5 sweep");
    cyc(1, 16'h2345, 1, 2, 1, 6, "R6 forward map on same cycle");
    cyc(1, 16'h2345, 0, 0, 0, 0, "R5 page2 now mapped");
    cyc(1, 16'h1800, 1, 1, 0, 0, "R6 R7 forward unmap");
    cyc(1, 16'h1800, 0, 0, 0, 0, "R7 page1 faults");
    cyc(1, 16'h3001, 1, 4, 1, 7, "R5 write other entry during lookup");
    cyc(1, 16'h4001, 0, 0, 0, 0, "R5 page4 updated");
    for (int k = 0; k < 200; k++)
      cyc(k % 4 != 3, 16'((k * 40503) & 16'hFFFF), k % 5 == 0, (k * 7) % 16, k % 2 == 0, k % 8,
          "R2 R3 R4 R6 R8 mixed");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule